// File: doc/BRIEF.md
# Write-back data cache with line maintenance

This block is a direct-mapped, write-back data cache that sits between a processor's load/store path and a simple memory port. It serves cached loads and stores, and uncached loads and stores that go straight to memory. It also serves four line-maintenance commands. A maintenance command picks its victim line in one of two ways: by the index bits of the address alone, or only when the stored tag matches the address. It then either writes a dirty victim back to memory before invalidating it, or throws the dirty contents away.

The cache holds 8 lines of 4 words of 32 bits each. A byte address splits, from the least significant bit upward, into byte offset [1:0], word select [3:2], line index [6:4] and tag [31:7]. The processor side takes one request at a time and reports completion with a one-cycle response pulse. The memory side moves one word per request/acknowledge handshake. Software uses the maintenance commands to keep cached and uncached views of the same address consistent.

Top module: `dcache_maint`

## Requirements
- R1: A request is accepted when `req_valid` is high and `busy` is low. `busy` is high from the cycle after acceptance until the cycle in which `rsp_valid` pulses for one cycle, and it is low in that cycle. A `req_valid` raised while `busy` is high has no effect.
- R2: A cached load (`req_cmd` = 0) returns the addressed word. On a hit it completes one cycle after acceptance with no memory traffic. On a miss it first fills the line with 4 word reads from memory.
- R3: A cached store (`req_cmd` = 1) writes the word into the cache and marks the line dirty. It makes no memory write, and a hit completes one cycle after acceptance.
- R4: A cached miss whose line is valid and dirty writes the 4 victim words to memory at the victim's address, in ascending word order, before the fill.
- R5: An uncached load (`req_cmd` = 2) or store (`req_cmd` = 3) makes exactly one memory access and neither reads nor changes the cache. An uncached load may therefore return stale data while a dirty cached copy exists.
- R6: Maintenance (`req_cmd` = 4) with `req_mop` = 2'b10 acts on the indexed line regardless of tag. If the line is valid and dirty, its 4 words are written back, and a valid line is then invalidated.
- R7: Maintenance with `req_mop` = 2'b11 acts only if the indexed line is valid and its tag equals the address tag. A dirty matched line is written back, and the matched line is then invalidated.
- R8: Maintenance with `req_mop` = 2'b00 invalidates the indexed line regardless of tag and never writes memory.
- R9: Maintenance with `req_mop` = 2'b01 invalidates the line only on a tag match, and it discards dirty data without any memory write.
- R10: A tag-checked maintenance command that finds no match completes one cycle after acceptance with no memory access.
- R11: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_we` and `mem_addr` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_cmd | input | 3 | 0 load, 1 store, 2 uncached load, 3 uncached store, 4 maintenance |
| req_mop | input | 2 | Maintenance kind: bit 1 writeback, bit 0 tag check |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| busy | output | 1 | Request in progress |
| rsp_valid | output | 1 | Completion pulse |
| rsp_rdata | output | 32 | Load result, valid with rsp_valid |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 32 | Word-aligned beat address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Beat accepted; read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The hardest situation to reach is a stale uncached read that a maintenance command then resolves. The stimulus must first leave a dirty line in the cache with a cached store, and then show through an uncached load that memory still holds the old word. Only after that can a flush or an init decide what the next uncached load returns. The bench builds this chain for every maintenance kind, including a dirty-victim eviction, and uses tags that differ while indexes collide. A second request is raised in the middle of a long miss, and later loads show that it had no effect.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int LINES     = 8;
    localparam int WORDS     = 4;
    localparam int BYTE_BITS = $clog2(DATA_W / 8);
    localparam int WORD_BITS = $clog2(WORDS);
    localparam int IDX_BITS  = $clog2(LINES);
    localparam int TAG_BITS  = ADDR_W - IDX_BITS - WORD_BITS - BYTE_BITS;

    typedef enum logic [2:0] {
        CMD_LOAD      = 3'd0,
        CMD_STORE     = 3'd1,
        CMD_UNC_LOAD  = 3'd2,
        CMD_UNC_STORE = 3'd3,
        CMD_MAINT     = 3'd4
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LOOKUP, ST_WB, ST_FILL, ST_UNC
    } state_e;

    typedef struct packed {
        logic [TAG_BITS-1:0]  tag;
        logic [IDX_BITS-1:0]  idx;
        logic [WORD_BITS-1:0] word;
        logic [BYTE_BITS-1:0] ofs;
    } addr_t;

    typedef struct packed {
        logic                valid;
        logic                dirty;
        logic [TAG_BITS-1:0] tag;
    } line_meta_t;

    function automatic logic mop_writeback(input logic [1:0] mop);
        return mop[1];
    endfunction

    function automatic logic mop_tagcheck(input logic [1:0] mop);
        return mop[0];
    endfunction
endpackage

// File: rtl/dcm_tag_store.sv
module dcm_tag_store
    import dcm_pkg::*;
#(
    parameter int N = LINES,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] rd_idx,
    output line_meta_t    rd_meta,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  line_meta_t    wr_meta
);
    line_meta_t meta_q [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) meta_q[i] <= '0;
        end else if (wr_en) begin
            meta_q[wr_idx] <= wr_meta;
        end
    end

    assign rd_meta = meta_q[rd_idx];
endmodule

// File: rtl/dcm_data_store.sv
module dcm_data_store
    import dcm_pkg::*;
#(
    parameter int N  = LINES,
    parameter int W  = WORDS,
    parameter int DW = DATA_W,
    localparam int IW = $clog2(N),
    localparam int WW = $clog2(W)
) (
    input  logic          clk,
    input  logic [IW-1:0] rd_idx,
    input  logic [WW-1:0] rd_word,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [WW-1:0] wr_word,
    input  logic [DW-1:0] wr_data
);
    logic [DW-1:0] words_q [N][W];

    always_ff @(posedge clk) begin
        if (wr_en) words_q[wr_idx][wr_word] <= wr_data;
    end

    assign rd_data = words_q[rd_idx][rd_word];
endmodule

// File: rtl/dcache_maint.sv
module dcache_maint
    import dcm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_cmd,
    input  logic [1:0]        req_mop,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam logic [WORD_BITS-1:0] LAST_W = WORD_BITS'(WORDS - 1);

    state_e               st_q, st_d;
    cmd_e                 cmd_q;
    logic [1:0]           mop_q;
    addr_t                a_q;
    logic [DATA_W-1:0]    wd_q;
    logic [WORD_BITS-1:0] cnt_q, cnt_d;
    logic                 rsp_q;
    logic [DATA_W-1:0]    rdata_q;

    line_meta_t           meta, tag_wmeta;
    logic                 tag_we, dat_we;
    logic [WORD_BITS-1:0] dat_word, rd_word;
    logic [DATA_W-1:0]    dat_wdata, rd_data;
    logic                 fin;
    logic [DATA_W-1:0]    fin_data;
    logic                 hit, maint_sel;
    addr_t                maddr;

    dcm_tag_store #(.N(LINES)) u_tags (
        .clk(clk), .rst(rst),
        .rd_idx(a_q.idx), .rd_meta(meta),
        .wr_en(tag_we), .wr_idx(a_q.idx), .wr_meta(tag_wmeta)
    );

    assign rd_word = (st_q == ST_WB) ? cnt_q : a_q.word;

    dcm_data_store #(.N(LINES), .W(WORDS), .DW(DATA_W)) u_data (
        .clk(clk),
        .rd_idx(a_q.idx), .rd_word(rd_word), .rd_data(rd_data),
        .wr_en(dat_we), .wr_idx(a_q.idx), .wr_word(dat_word), .wr_data(dat_wdata)
    );

    assign hit       = meta.valid && (meta.tag == a_q.tag);
    assign maint_sel = mop_tagcheck(mop_q) ? hit : meta.valid;

    always_comb begin
        st_d      = st_q;
        cnt_d     = cnt_q;
        fin       = 1'b0;
        fin_data  = rd_data;
        tag_we    = 1'b0;
        tag_wmeta = meta;
        dat_we    = 1'b0;
        dat_word  = a_q.word;
        dat_wdata = wd_q;
        case (st_q)
            ST_IDLE: if (req_valid) st_d = ST_LOOKUP;
            ST_LOOKUP: begin
                case (cmd_q)
                    CMD_LOAD, CMD_STORE: begin
                        if (hit) begin
                            fin  = 1'b1;
                            st_d = ST_IDLE;
                            if (cmd_q == CMD_STORE) begin
                                dat_we          = 1'b1;
                                tag_we          = 1'b1;
                                tag_wmeta.dirty = 1'b1;
                            end
                        end else begin
                            cnt_d = '0;
                            st_d  = (meta.valid && meta.dirty) ? ST_WB : ST_FILL;
                        end
                    end
                    CMD_UNC_LOAD, CMD_UNC_STORE: st_d = ST_UNC;
                    CMD_MAINT: begin
                        if (maint_sel && mop_writeback(mop_q) && meta.dirty) begin
                            cnt_d = '0;
                            st_d  = ST_WB;
                        end else begin
                            fin  = 1'b1;
                            st_d = ST_IDLE;
                            if (maint_sel) begin
                                tag_we    = 1'b1;
                                tag_wmeta = '0;
                            end
                        end
                    end
                    default: begin
                        fin  = 1'b1;
                        st_d = ST_IDLE;
                    end
                endcase
            end
            ST_WB: begin
                if (mem_ack) begin
                    cnt_d = cnt_q + 1'b1;
                    if (cnt_q == LAST_W) begin
                        if (cmd_q == CMD_MAINT) begin
                            tag_we    = 1'b1;
                            tag_wmeta = '0;
                            fin       = 1'b1;
                            st_d      = ST_IDLE;
                        end else begin
                            st_d = ST_FILL;
                        end
                    end
                end
            end
            ST_FILL: begin
                if (mem_ack) begin
                    dat_we    = 1'b1;
                    dat_word  = cnt_q;
                    dat_wdata = mem_rdata;
                    cnt_d     = cnt_q + 1'b1;
                    if (cnt_q == LAST_W) begin
                        tag_we    = 1'b1;
                        tag_wmeta = '{valid: 1'b1, dirty: 1'b0, tag: a_q.tag};
                        st_d      = ST_LOOKUP;
                    end
                end
            end
            ST_UNC: begin
                if (mem_ack) begin
                    fin      = 1'b1;
                    fin_data = mem_rdata;
                    st_d     = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            cmd_q   <= CMD_LOAD;
            mop_q   <= '0;
            a_q     <= '0;
            wd_q    <= '0;
            cnt_q   <= '0;
            rsp_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            rsp_q <= fin;
            if (fin) rdata_q <= fin_data;
            if (st_q == ST_IDLE && req_valid) begin
                cmd_q <= cmd_e'(req_cmd);
                mop_q <= req_mop;
                a_q   <= addr_t'(req_addr);
                wd_q  <= req_wdata;
            end
        end
    end

    always_comb begin
        maddr = a_q;
        maddr.ofs = '0;
        if (st_q == ST_WB) begin
            maddr.tag  = meta.tag;
            maddr.word = cnt_q;
        end else if (st_q == ST_FILL) begin
            maddr.word = cnt_q;
        end
    end

    assign busy      = (st_q != ST_IDLE);
    assign rsp_valid = rsp_q;
    assign rsp_rdata = rdata_q;
    assign mem_req   = (st_q == ST_WB) || (st_q == ST_FILL) || (st_q == ST_UNC);
    assign mem_we    = (st_q == ST_WB) || (st_q == ST_UNC && cmd_q == CMD_UNC_STORE);
    assign mem_addr  = maddr;
    assign mem_wdata = (st_q == ST_WB) ? rd_data : wd_q;

    assert_busy_fall_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> rsp_valid);
    assert_rsp_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
    assert_mem_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    // R9 is also covered: both init kinds have mop bit 1 clear
    assert_init_no_mem_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_q == CMD_MAINT && !mop_q[1]) |-> !mem_req);
    assert_tagmiss_fast_R10: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_LOOKUP && cmd_q == CMD_MAINT && mop_q[0] && !hit) |=> (rsp_valid && !busy));
    assert_unc_no_cache_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_UNC) |-> (!tag_we && !dat_we));
endmodule

// File: tb/dcache_maint_test.sv
`timescale 1ns/1ps
module dcache_maint_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [2:0]  req_cmd;
    logic [1:0]  req_mop;
    logic [31:0] req_addr, req_wdata;
    logic        busy, rsp_valid;
    logic [31:0] rsp_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    always #2.5 clk = ~clk;

    dcache_maint uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_mop(req_mop), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit timed_out = 0;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] memdef(input logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    // bench memory
    logic [31:0] bmem [logic [31:0]];
    logic [31:0] wlog [$];
    int rbeats = 0;
    always @(posedge clk) begin
        cyc++;
        if (rst) mem_ack <= 1'b0;
        else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                bmem[mem_addr] = mem_wdata;
                wlog.push_back(mem_addr);
            end else begin
                mem_rdata <= bmem.exists(mem_addr) ? bmem[mem_addr] : memdef(mem_addr);
                rbeats++;
            end
        end else mem_ack <= 1'b0;
    end

    // per-clock handshake check (R11)
    logic pv_req = 0, pv_ack = 0;
    logic [31:0] pv_addr = 0;
    always @(negedge clk) begin
        if (!rst && pv_req && !pv_ack)
            chk(mem_req && mem_addr == pv_addr, "R11 addr hold", mem_addr, pv_addr);
        pv_req  = mem_req;
        pv_ack  = mem_ack;
        pv_addr = mem_addr;
    end

    // reference model
    bit          mv [8];
    bit          md [8];
    logic [24:0] mt [8];
    logic [31:0] mdat [8][4];
    logic [31:0] smem [logic [31:0]];
    logic [31:0] exp_w [$];

    function automatic logic [31:0] smem_rd(input logic [31:0] a);
        return smem.exists(a) ? smem[a] : memdef(a);
    endfunction

    task automatic model_wb(input int idx);
        for (int k = 0; k < 4; k++) begin
            logic [31:0] a;
            a = {mt[idx], 3'(idx), 2'(k), 2'b00};
            smem[a] = mdat[idx][k];
            exp_w.push_back(a);
        end
    endtask

    task automatic model(input int cmd, input logic [1:0] mop, input logic [31:0] addr,
                         input logic [31:0] wd, output logic [31:0] rd, output int nr);
        int idx, w;
        logic [24:0] tg;
        bit hit, sel;
        logic [31:0] al;
        idx = int'(addr[6:4]); w = int'(addr[3:2]); tg = addr[31:7];
        al = {addr[31:2], 2'b00};
        hit = mv[idx] && mt[idx] == tg;
        rd = '0; nr = 0;
        exp_w.delete();
        case (cmd)
            0, 1: begin
                if (!hit) begin
                    if (mv[idx] && md[idx]) model_wb(idx);
                    for (int k = 0; k < 4; k++)
                        mdat[idx][k] = smem_rd({tg, 3'(idx), 2'(k), 2'b00});
                    nr = 4; mv[idx] = 1; md[idx] = 0; mt[idx] = tg;
                end
                if (cmd == 1) begin mdat[idx][w] = wd; md[idx] = 1; end
                rd = mdat[idx][w];
            end
            2: begin rd = smem_rd(al); nr = 1; end
            3: begin smem[al] = wd; exp_w.push_back(al); end
            default: begin
                sel = mop[0] ? hit : mv[idx];
                if (sel && mop[1] && md[idx]) model_wb(idx);
                if (sel) begin mv[idx] = 0; md[idx] = 0; end
            end
        endcase
    endtask

    task automatic do_op(input int cmd, input logic [1:0] mop, input logic [31:0] addr,
                         input logic [31:0] wd, input int exp_lat, input string rq, input bit poke);
        logic [31:0] erd;
        int enr, lat;
        bit ok;
        model(cmd, mop, addr, wd, erd, enr);
        wlog.delete(); rbeats = 0;
        @(negedge clk);
        req_valid = 1; req_cmd = 3'(cmd); req_mop = mop; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        lat = 1;
        chk(busy === 1'b1, {rq, " R1 busy after accept"}, 32'(busy), 1);
        while (!rsp_valid && cyc < 150000) begin
            if (poke && lat == 2) begin
                req_valid = 1; req_cmd = 3'd1; req_addr = 32'h5040; req_wdata = 32'hDEAD0000;
            end else req_valid = 0;
            @(negedge clk);
            lat++;
        end
        req_valid = 0;
        if (!rsp_valid) begin
            timed_out = 1;
            chk(0, "watchdog", cyc, 150000);
            return;
        end
        chk(busy === 1'b0, {rq, " R1 busy low at response"}, 32'(busy), 0);
        if (cmd == 0 || cmd == 2) chk(rsp_rdata === erd, {rq, " read data"}, rsp_rdata, erd);
        ok = (wlog.size() == exp_w.size());
        if (ok) foreach (exp_w[i]) if (wlog[i] !== exp_w[i]) ok = 0;
        chk(ok, {rq, " memory write sequence"}, wlog.size(), exp_w.size());
        chk(rbeats == enr, {rq, " memory read beats"}, rbeats, enr);
        if (exp_lat > 0) chk(lat == exp_lat, {rq, " latency"}, lat, exp_lat);
    endtask

    initial begin
        rst = 1; req_valid = 0; req_cmd = 0; req_mop = 0; req_addr = 0; req_wdata = 0;
        foreach (mv[i]) begin mv[i] = 0; md[i] = 0; mt[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        chk(busy === 0 && rsp_valid === 0 && mem_req === 0, "R1 reset state",
            {busy, rsp_valid, mem_req}, 0);

        do_op(0, 2'b00, 32'h1000, 0, -1, "R2 load miss", 0);
        do_op(0, 2'b00, 32'h1004, 0, 2, "R2 load hit", 0);
        do_op(1, 2'b00, 32'h1000, 32'h11110000, 2, "R3 store hit", 0);
        do_op(2, 2'b00, 32'h1000, 0, -1, "R5 stale uncached load", 0);
        do_op(4, 2'b11, 32'h1000, 0, -1, "R7 flush by address", 0);
        do_op(2, 2'b00, 32'h1000, 0, -1, "R7 uncached load after flush", 0);

        do_op(1, 2'b00, 32'h2000, 32'h22220000, -1, "R3 store miss", 0);
        do_op(1, 2'b00, 32'h3008, 32'h33330000, -1, "R4 dirty eviction with ignored request R1", 1);
        do_op(2, 2'b00, 32'h2000, 0, -1, "R4 victim reached memory", 0);
        do_op(0, 2'b00, 32'h5040, 0, -1, "R1 ignored request left no data", 0);

        do_op(4, 2'b01, 32'h1008, 0, 2, "R10 init by address tag miss", 0);
        do_op(4, 2'b11, 32'h1008, 0, 2, "R10 flush by address tag miss", 0);
        do_op(4, 2'b01, 32'h3008, 0, -1, "R9 init by address", 0);
        do_op(2, 2'b00, 32'h3008, 0, -1, "R9 uncached sees old data", 0);
        do_op(0, 2'b00, 32'h3008, 0, -1, "R9 cached reload old data", 0);

        do_op(1, 2'b00, 32'h1010, 32'h44440000, -1, "R3 store idx1", 0);
        do_op(4, 2'b00, 32'hFFF0010, 0, 2, "R8 init by index", 0);
        do_op(2, 2'b00, 32'h1010, 0, -1, "R8 uncached sees old data", 0);
        do_op(0, 2'b00, 32'h1014, 0, -1, "R8 line was invalidated", 0);

        do_op(1, 2'b00, 32'h102C, 32'h55550000, -1, "R3 store idx2", 0);
        do_op(4, 2'b10, 32'hABC0020, 0, -1, "R6 flush by index", 0);
        do_op(2, 2'b00, 32'h102C, 0, -1, "R6 uncached sees flushed data", 0);
        do_op(4, 2'b10, 32'hABC0020, 0, 2, "R6 flush by index invalid line", 0);

        do_op(3, 2'b00, 32'h1030, 32'h66660000, -1, "R5 uncached store", 0);
        do_op(0, 2'b00, 32'h1030, 0, -1, "R5 fill sees uncached store", 0);
        do_op(1, 2'b00, 32'h1040, 32'h77770000, -1, "R3 store idx4", 0);
        do_op(3, 2'b00, 32'h1040, 32'h88880000, -1, "R5 uncached store beside cache", 0);
        do_op(0, 2'b00, 32'h1040, 0, 2, "R5 cache untouched by uncached store", 0);

        foreach (smem[k])
            chk(bmem.exists(k) && bmem[k] === smem[k], "R4 final memory image",
                bmem.exists(k) ? bmem[k] : 32'hx, smem[k]);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #900000;
        if (!timed_out) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 180000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        end
        $finish;
    end
endmodule